// File: doc/BRIEF.md
# Word-Fed CRC-16 Accumulator

This block is a small register-mapped checksum engine that software feeds one data word at a time in order to check the integrity of a received or outgoing frame. Each write to the feed register folds the low 12 bits of the written word into a running 16-bit CRC, and one cycle later the new CRC can be read from the result register. A control register clears the engine and reports how many words have been folded since the last clear. Before trusting the engine, software can run a fixed known-answer sequence.

The CRC uses the reflected form of the 16-bit CCITT polynomial x^16+x^12+x^5+1 (constant 0x8408), shifting toward the least significant bit. Data bits enter least significant bit first, and all 12 bits of each word are folded. The seed that loads on reset or clear is 0x950C. With this seed, the words 0x0CC, 0x0F5, 0x0F1, 0x0A7 fed in that order produce 0x51DF. The register map has three locations on a 2-bit address. Reads are combinational from the current register state. A write takes effect at the rising clock edge on which `bus_wr` is high.

Top module: `crc_word_engine`

## Requirements
- R1: After reset the control register reads 0x0000 and the result register reads the seed 0x950C.
- R2: A write to the control register (address 0) with bit 15 set loads the CRC with the seed and clears the count. Both changes are visible on the next cycle.
- R3: A write to the control register with bit 15 clear leaves both the CRC and the count unchanged.
- R4: A write to the feed register (address 1) folds data bits 11:0 into the CRC, bit 0 first. For each bit, feedback = crc[0] xor data bit, then crc = (crc >> 1) xor (feedback ? 0x8408 : 0). The result register (address 2) shows the new value on the cycle after the write.
- R5: Bits 15:12 of a feed write have no effect on the CRC.
- R6: Each feed write increments the count by one. The count stays at 0xFFF once it reaches that value, while the CRC keeps folding.
- R7: After a clear and feed words 0x0CC, 0x0F5, 0x0F1, 0x0A7, the count reads 4 and the result reads 0x51DF.
- R8: A read of the control register returns the count in bits 11:0 and zero in bits 15:12.
- R9: Reads of any register do not change the CRC or the count.
- R10: Address 3 and reads of the feed register return 0x0000. Writes to address 3 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 feed, 2 result, 3 unused |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |

## Verification
A corrupted CRC state shows up on the result register on the very next read. Because every later fold depends on the current value, an error made by one bad fold is never cancelled by later words. The bench therefore checks the result after each write against a bit-serial model. A wrong count appears in the low 12 bits of the control register one cycle after the feed write that produced it. The saturation case needs 4095 feeds before an error can appear, so the bench drives the count to its limit and writes past it.

// File: rtl/crc_eng_pkg.sv
`timescale 1ns/1ps
package crc_eng_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_FEED   = 2'd1,
        SEL_RESULT = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/crcw_fold.sv
`timescale 1ns/1ps
module crcw_fold #(
    parameter int              CRC_W  = 16,
    parameter int              FOLD_W = 12,
    parameter logic [CRC_W-1:0] POLY  = 16'h8408
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [FOLD_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] stage [0:FOLD_W];

    assign stage[0] = crc_in;

    for (genvar b = 0; b < FOLD_W; b++) begin : g_bit
        logic fb;
        assign fb          = stage[b][0] ^ data_in[b];
        assign stage[b+1]  = (stage[b] >> 1) ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[FOLD_W];

endmodule

// File: rtl/crcw_accum.sv
`timescale 1ns/1ps
module crcw_accum #(
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] SEED  = 16'h950C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CRC_W-1:0] crc_next,
    output logic [CRC_W-1:0] crc
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.crc = SEED;
        end else if (load) begin
            st_d.crc = crc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.crc <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc = st_q.crc;

    assert_clear_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc == SEED));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load) |=> $stable(crc));

endmodule

// File: rtl/crcw_counter.sv
`timescale 1ns/1ps
module crcw_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (step && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    assert_count_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && count == CNT_MAX) |=> (count == CNT_MAX));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && count != CNT_MAX) |=> (count == $past(count) + CNT_W'(1)));

    assert_count_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

endmodule

// File: rtl/crc_word_engine.sv
`timescale 1ns/1ps
module crc_word_engine #(
    parameter int                REG_W   = 16,
    parameter int                CRC_W   = 16,
    parameter int                FOLD_W  = 12,
    parameter int                CNT_W   = 12,
    parameter int                CLR_BIT = 15,
    parameter logic [CRC_W-1:0]  POLY    = 16'h8408,
    parameter logic [CRC_W-1:0]  SEED    = 16'h950C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata
);

    import crc_eng_pkg::*;

    localparam int PAD_W = REG_W - CNT_W;

    reg_sel_e         sel;
    logic             do_clear;
    logic             do_feed;
    logic [CRC_W-1:0] crc_cur;
    logic [CRC_W-1:0] crc_nxt;
    logic [CNT_W-1:0] fed_count;

    assign sel      = reg_sel_e'(bus_addr);
    assign do_clear = bus_wr && (sel == SEL_CTRL) && bus_wdata[CLR_BIT];
    assign do_feed  = bus_wr && (sel == SEL_FEED);

    crcw_fold #(
        .CRC_W  (CRC_W),
        .FOLD_W (FOLD_W),
        .POLY   (POLY)
    ) u_fold (
        .crc_in  (crc_cur),
        .data_in (bus_wdata[FOLD_W-1:0]),
        .crc_out (crc_nxt)
    );

    crcw_accum #(
        .CRC_W (CRC_W),
        .SEED  (SEED)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (do_clear),
        .load     (do_feed),
        .crc_next (crc_nxt),
        .crc      (crc_cur)
    );

    crcw_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (do_clear),
        .step  (do_feed),
        .count (fed_count)
    );

    always_comb begin
        case (sel)
            SEL_CTRL:   bus_rdata = {{PAD_W{1'b0}}, fed_count};
            SEL_RESULT: bus_rdata = REG_W'(crc_cur);
            default:    bus_rdata = '0;
        endcase
    end

    assert_feed_moves_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_feed && fed_count != {CNT_W{1'b1}}) |=> (fed_count != $past(fed_count)));

    assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_NONE) |=> ($stable(crc_cur) && $stable(fed_count)));

    assert_no_write_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(crc_cur) && $stable(fed_count)));

endmodule

// File: tb/crc_word_engine_bench.sv
`timescale 1ns/1ps
module crc_word_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SEED = 16'h950C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd3;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic probe = 1'b0;
    logic done = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    logic [15:0] m_crc;
    int          m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_word_engine u_crc_word_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [15:0] mdl_fold(input logic [15:0] c, input logic [11:0] d);
        logic [15:0] r;
        r = c ^ {4'h0, d};
        for (int i = 0; i < 12; i++) begin
            r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        end
        return r;
    endfunction

    // Each task starts at a falling edge and ends at the next one.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        if (a == 2'd1) begin
            m_crc = mdl_fold(m_crc, d[11:0]);
            if (m_cnt < 4095) m_cnt++;
        end else if (a == 2'd0 && d[15]) begin
            m_crc = SEED;
            m_cnt = 0;
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic check_state(input string tag);
        rd(2'd0, 16'(m_cnt), {tag, " count"});
        rd(2'd2, m_crc, {tag, " result"});
    endtask

    // Monitor: compares a quarter period after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (probe) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [15:0] keep_crc;
        m_crc = SEED;
        m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values, R10 unmapped and feed reads
        rd(2'd0, 16'h0000, "R1 control after reset");
        rd(2'd2, 16'h950C, "R1 result after reset");
        rd(2'd1, 16'h0000, "R10 feed register reads zero");
        rd(2'd3, 16'h0000, "R10 unmapped reads zero");

        // R7 known-answer sequence
        wr(2'd0, 16'h8000);
        wr(2'd1, 16'h00CC);
        wr(2'd1, 16'h00F5);
        wr(2'd1, 16'h00F1);
        wr(2'd1, 16'h00A7);
        rd(2'd0, 16'h0004, "R7 known-answer count");
        rd(2'd2, 16'h51DF, "R7 known-answer result");
        rd(2'd2, m_crc, "R7 model agrees with known answer");

        // R9 repeated reads leave state alone
        rd(2'd2, 16'h51DF, "R9 result reread");
        rd(2'd0, 16'h0004, "R9 count reread");

        // R3 control write without clear bit
        wr(2'd0, 16'h7FFF);
        rd(2'd0, 16'h0004, "R3 count kept after non-clear write");
        rd(2'd2, 16'h51DF, "R3 result kept after non-clear write");

        // R10 write to unmapped address
        wr(2'd3, 16'hFFFF);
        rd(2'd0, 16'h0004, "R10 count kept after unmapped write");
        rd(2'd2, 16'h51DF, "R10 result kept after unmapped write");

        // R4 single fold visible the cycle after
        wr(2'd1, 16'h0123);
        rd(2'd2, m_crc, "R4 result one cycle after feed");
        // R8 control upper bits zero
        rd(2'd0, 16'h0005, "R8 control shows count with zero upper bits");

        // R5 upper nibble ignored: same low bits, different high bits
        wr(2'd0, 16'h8000);
        wr(2'd1, 16'h00CC);
        keep_crc = m_crc;
        wr(2'd0, 16'h8000);
        wr(2'd1, 16'hF0CC);
        rd(2'd2, keep_crc, "R5 upper nibble has no effect");

        // R4 pattern sweep against model
        wr(2'd0, 16'h8000);
        rd(2'd2, 16'h950C, "R2 result reseeded by clear");
        rd(2'd0, 16'h0000, "R2 count cleared");
        lfsr = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr(2'd1, lfsr);
            check_state("R4 pattern");
        end
        wr(2'd1, 16'h0FFF);
        check_state("R4 all-ones word");
        wr(2'd1, 16'h0000);
        check_state("R4 zero word");

        // R6 saturation
        wr(2'd0, 16'h8000);
        for (int i = 0; i < 4094; i++) begin
            wr(2'd1, 16'(i));
        end
        rd(2'd0, 16'h0FFE, "R6 count below limit");
        wr(2'd1, 16'h0055);
        rd(2'd0, 16'h0FFF, "R6 count reaches limit");
        wr(2'd1, 16'h0AAA);
        rd(2'd0, 16'h0FFF, "R6 count holds at limit");
        rd(2'd2, m_crc, "R6 CRC still folds at limit");

        // R2 clear after saturation
        wr(2'd0, 16'h8001);
        rd(2'd0, 16'h0000, "R2 clear from saturated count");
        rd(2'd2, 16'h950C, "R2 seed after clear");

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R7 run incomplete actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule